// File: doc/BRIEF.md
# Floating-Point Compare Condition Queue

This block records the outcome of a floating-point compare as condition bits in a 32-bit status word. A comparator elsewhere in the pipeline classifies each pair of operands into one of four relations and reports whether either operand was a NaN or a signaling NaN. On the strobe cycle the block takes that relation, a 5-bit condition mask and a target index from the instruction. It turns them into one result bit and writes that bit into its condition state.

Two writeback modes exist. With a target index of zero the compare is queued: a history queue below the current condition bit shifts one place toward the low end, the old current bit enters the queue at its top, and the new result becomes the current bit. With a nonzero target index, the result goes only to one bit of a directly addressed array, and the current bit and the queue keep their values. The block also raises an invalid-operation pulse when the compare semantics call for one. That pulse is produced on the same edge as the condition write, so the exception status is never seen behind the condition bits.

Top module: `fp_cond_queue`

## Requirements
- R1: A synchronous active-low reset clears the current bit, the queue and the targeted array, so `status_o` reads 0 and `invalid_o` is low.
- R2: `rel_i` is one-hot, with bit 3 = greater, bit 2 = less, bit 1 = equal and bit 0 = unordered. The result bit is `cond_mask_i[4]` for greater, `[3]` for less, `[2]` for equal and `[1]` for unordered.
- R3: On a legal strobe with `target_i` = 0, the queue (`status_o[25:15]`) shifts down one place and drops its lowest bit. The previous current bit (`status_o[26]`) enters `status_o[25]`, and the new result is written to `status_o[26]`.
- R4: On a legal strobe with `target_i` = y in 1..6, the result is written to `status_o[14-(y-1)]` only. Bits 26..15 and the other targeted bits keep their values.
- R5: A strobe with `target_i` = 7, which lies beyond the six-entry array, leaves `status_o` unchanged.
- R6: When `cmp_valid_i` is low, `status_o` keeps its value and `invalid_o` stays low.
- R7: A strobe whose `rel_i` is not exactly one-hot is illegal. It changes no status bit and raises no invalid pulse.
- R8: `cond_mask_i[0]` = 1 selects a signaling compare, which raises invalid when `any_nan_i` is high. With `cond_mask_i[0]` = 0 the compare is quiet and raises invalid only when `any_snan_i` is high.
- R9: `invalid_o` is a one-cycle pulse in the cycle after a legal strobe. The condition bits written by that strobe become visible in that same cycle.
- R10: Bits 31..27 and 8..0 of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid_i | input | 1 | Compare result strobe |
| rel_i | input | 4 | One-hot relation: greater, less, equal, unordered |
| cond_mask_i | input | 5 | Condition mask; bit 0 selects signaling compare |
| target_i | input | 3 | 0 = queued write, 1..6 = targeted bit |
| any_nan_i | input | 1 | Either operand is a NaN |
| any_snan_i | input | 1 | Either operand is a signaling NaN |
| status_o | output | 32 | Status word holding the current bit, queue and targeted array |
| invalid_o | output | 1 | Invalid-operation pulse for the last compare |

## Verification
The bench runs thirteen queued compares in a row, so the oldest history bits fall off the low end of the queue. A design that wrapped those bits around, or kept them, would leave stray ones in bit 15 or corrupt the current bit. Targeted writes to every index must show that the current bit and the queue stay frozen and that index 1 lands on the highest array position. A reversed or off-by-one index would flip the wrong bit. Index 7 and non-one-hot relations are applied on top of known nonzero state, so a design that decoded them anyway would show a changed word or a spurious invalid pulse. Quiet and signaling compares are run against plain and signaling NaN inputs, which catches a design that swaps the meaning of mask bit 0.

// File: rtl/fp_cond_pkg.sv
// Package: shared encodings for the compare condition queue.
// Assumes relation codes arrive one-hot from the comparator.
package fp_cond_pkg;

    // One-hot relation bit positions.
    localparam int REL_W      = 4;
    localparam int REL_GT     = 3;
    localparam int REL_LT     = 2;
    localparam int REL_EQ     = 1;
    localparam int REL_UN     = 0;

    // Condition mask layout: bits 4..1 map to relations, bit 0 selects signaling.
    localparam int MASK_W     = 5;
    localparam int MASK_SIG   = 0;

    // Result of decoding one compare.
    typedef struct packed {
        logic legal;      // relation code is exactly one-hot
        logic result;     // selected condition bit
        logic raise_inv;  // invalid-operation condition
    } cmp_outcome_t;

endpackage

// File: rtl/fp_cond_resolve.sv
// Module: fp_cond_resolve
// Turns a relation code and an instruction condition mask into one result bit
// and an invalid-operation flag. Purely combinational.
// Assumes the NaN indications are valid in the same cycle as the relation.
module fp_cond_resolve
    import fp_cond_pkg::*;
(
    input  logic [REL_W-1:0]  rel_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              any_nan_i,
    input  logic              any_snan_i,
    output cmp_outcome_t      outcome_o
);

    // Mask bits 4..1 line up with relation bits 3..0.
    logic [REL_W-1:0] sel_bits;
    assign sel_bits = mask_i[MASK_W-1:1];

    // Decode legality, pick the result bit, and evaluate the invalid rule.
    always_comb begin
        outcome_o.legal     = $onehot(rel_i);
        outcome_o.result    = |(rel_i & sel_bits);
        outcome_o.raise_inv = mask_i[MASK_SIG] ? any_nan_i : any_snan_i;
    end

endmodule

// File: rtl/fp_cond_history.sv
// Module: fp_cond_history
// Holds the current condition bit and the history queue below it.
// A push moves the whole {current, queue} field one place toward the low end:
// the lowest queue bit is lost, the old current bit enters the queue top,
// and the new result becomes current. Synchronous active-low reset.
module fp_cond_history #(
    parameter int QDEPTH = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              bit_i,
    output logic              cur_o,
    output logic [QDEPTH-1:0] queue_o
);

    // Update current bit and queue on a push; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o   <= 1'b0;
            queue_o <= '0;
        end else if (push_i) begin
            queue_o <= {cur_o, queue_o[QDEPTH-1:1]};
            cur_o   <= bit_i;
        end
    end

endmodule

// File: rtl/fp_cond_direct.sv
// Module: fp_cond_direct
// Array of directly addressed condition bits. Index value k+1 selects entry k;
// index 0 and indices above the array size select nothing.
// Synchronous active-low reset.
module fp_cond_direct #(
    parameter int CA_N = 6,
    parameter int Y_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [Y_W-1:0]  idx_i,
    input  logic            bit_i,
    output logic [CA_N-1:0] ca_o
);

    for (genvar k = 0; k < CA_N; k++) begin : g_entry
        logic hit;
        assign hit = wr_i && (idx_i == Y_W'(k + 1));

        // Write this entry when it is addressed; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)   ca_o[k] <= 1'b0;
            else if (hit) ca_o[k] <= bit_i;
        end
    end

endmodule

// File: rtl/fp_cond_queue.sv
// Module: fp_cond_queue (top)
// Records floating-point compare results as condition bits of a status word.
// Queued mode (target 0) pushes the history; targeted mode writes one array
// bit. The invalid pulse is registered on the same edge as the condition
// write. Assumes rel_i is one-hot on valid strobes; other codes are dropped.
module fp_cond_queue
    import fp_cond_pkg::*;
#(
    parameter int SW     = 32,
    parameter int C_POS  = 26,
    parameter int QDEPTH = 11,
    parameter int CA_N   = 6,
    parameter int Y_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid_i,
    input  logic [REL_W-1:0]  rel_i,
    input  logic [MASK_W-1:0] cond_mask_i,
    input  logic [Y_W-1:0]    target_i,
    input  logic              any_nan_i,
    input  logic              any_snan_i,
    output logic [SW-1:0]     status_o,
    output logic              invalid_o
);

    localparam int CQ_LO   = C_POS - QDEPTH;
    localparam int CA0_POS = CQ_LO - 1;

    cmp_outcome_t      outcome;
    logic              accept;
    logic              push;
    logic              wr_direct;
    logic              cur_bit;
    logic [QDEPTH-1:0] queue;
    logic [CA_N-1:0]   ca_bits;

    fp_cond_resolve i_resolve (
        .rel_i      (rel_i),
        .mask_i     (cond_mask_i),
        .any_nan_i  (any_nan_i),
        .any_snan_i (any_snan_i),
        .outcome_o  (outcome)
    );

    // Route a legal strobe to the queued or the targeted path.
    always_comb begin
        accept    = cmp_valid_i && outcome.legal;
        push      = accept && (target_i == '0);
        wr_direct = accept && (target_i != '0);
    end

    fp_cond_history #(.QDEPTH(QDEPTH)) i_history (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .bit_i   (outcome.result),
        .cur_o   (cur_bit),
        .queue_o (queue)
    );

    fp_cond_direct #(.CA_N(CA_N), .Y_W(Y_W)) i_direct (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (wr_direct),
        .idx_i (target_i),
        .bit_i (outcome.result),
        .ca_o  (ca_bits)
    );

    // Register the invalid pulse alongside the condition update.
    always_ff @(posedge clk) begin
        if (!rst_n) invalid_o <= 1'b0;
        else        invalid_o <= accept && outcome.raise_inv;
    end

    // Assemble the status word; unused positions read zero.
    always_comb begin
        status_o                  = '0;
        status_o[C_POS]           = cur_bit;
        status_o[C_POS-1:CQ_LO]   = queue;
        for (int k = 0; k < CA_N; k++) begin
            status_o[CA0_POS-k] = ca_bits[k];
        end
    end

endmodule

// File: rtl/fp_cond_queue_checker.sv
// Module: fp_cond_queue_checker
// Temporal properties of the compare condition queue, bound into the top.
module fp_cond_queue_checker #(
    parameter int SW     = 32,
    parameter int C_POS  = 26,
    parameter int QDEPTH = 11,
    parameter int CA_N   = 6,
    parameter int Y_W    = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmp_valid_i,
    input logic [3:0]     rel_i,
    input logic [Y_W-1:0] target_i,
    input logic [SW-1:0]  status_o,
    input logic           invalid_o
);

    localparam int CQ_LO  = C_POS - QDEPTH;
    localparam int CA_LO  = CQ_LO - CA_N;
    localparam logic [SW-1:0] USED =
        ((SW'(1) << (C_POS + 1)) - SW'(1)) & ~((SW'(1) << CA_LO) - SW'(1));

    // Reset clears the status word and the invalid pulse.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0) && !invalid_o);

    // Queued write: old current bit lands at the top of the queue.
    assert_queue_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid_i && $onehot(rel_i) && (target_i == '0)
        |=> status_o[C_POS-1] == $past(status_o[C_POS]));

    // Targeted write leaves current bit and queue alone.
    assert_target_keeps_queue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid_i && (target_i != '0) |=> $stable(status_o[C_POS:CQ_LO]));

    // Out-of-range index changes nothing.
    assert_out_of_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid_i && (int'(target_i) > CA_N) |=> $stable(status_o));

    // Idle cycles hold the word and keep invalid low.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid_i |=> $stable(status_o) && !invalid_o);

    // Illegal relation codes are dropped.
    assert_illegal_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid_i && !$onehot(rel_i) |=> $stable(status_o) && !invalid_o);

    // Invalid only follows a strobe.
    assert_invalid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> $past(cmp_valid_i));

    // Unused status bits stay zero.
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~USED) == '0);

endmodule

bind fp_cond_queue fp_cond_queue_checker #(
    .SW(SW), .C_POS(C_POS), .QDEPTH(QDEPTH), .CA_N(CA_N), .Y_W(Y_W)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_valid_i (cmp_valid_i),
    .rel_i       (rel_i),
    .target_i    (target_i),
    .status_o    (status_o),
    .invalid_o   (invalid_o)
);

// File: tb/test_fp_cond_queue.sv
// Scoreboard bench: the driver applies one cycle of stimulus and pushes the
// expected status; the monitor pops and compares one cycle later.
module test_fp_cond_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid_i = 1'b0;
    logic [3:0]  rel_i = '0;
    logic [4:0]  cond_mask_i = '0;
    logic [2:0]  target_i = '0;
    logic        any_nan_i = 1'b0;
    logic        any_snan_i = 1'b0;
    logic [31:0] status_o;
    logic        invalid_o;

    always #5 clk = ~clk;

    fp_cond_queue i_fp_cond_queue (
        .clk(clk), .rst_n(rst_n), .cmp_valid_i(cmp_valid_i), .rel_i(rel_i),
        .cond_mask_i(cond_mask_i), .target_i(target_i), .any_nan_i(any_nan_i),
        .any_snan_i(any_snan_i), .status_o(status_o), .invalid_o(invalid_o)
    );

    typedef struct {
        logic [31:0] word;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 0;

    // Reference state
    logic        m_c = 1'b0;
    logic [10:0] m_q = '0;
    logic [5:0]  m_ca = '0;

    localparam logic [3:0] GT = 4'b1000, LT = 4'b0100, EQ = 4'b0010, UN = 4'b0001;

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[26] = m_c;
        w[25:15] = m_q;
        for (int k = 0; k < 6; k++) w[14-k] = m_ca[k];
        return w;
    endfunction

    task automatic check(input logic [31:0] aw, input logic ai,
                         input logic [31:0] ew, input logic ei, input string tag);
        n_checks++;
        if (aw !== ew || ai !== ei) begin
            n_fail++;
            $display("FAIL %s: status=%h invalid=%b expected status=%h invalid=%b",
                     tag, aw, ai, ew, ei);
        end
    endtask

    // Driver: one cycle of stimulus, reference update, expected push.
    task automatic drive(input logic v, input logic [3:0] rel, input logic [4:0] mask,
                         input logic [2:0] y, input logic nan, input logic snan,
                         input string tag);
        exp_t e;
        logic legal, res, inv;
        @(negedge clk);
        cmp_valid_i = v; rel_i = rel; cond_mask_i = mask; target_i = y;
        any_nan_i = nan; any_snan_i = snan;
        legal = v && $onehot(rel);
        res = (rel[3] & mask[4]) | (rel[2] & mask[3]) | (rel[1] & mask[2]) | (rel[0] & mask[1]);
        inv = legal && (mask[0] ? nan : snan);
        if (legal) begin
            if (y == 0) begin
                m_q = {m_c, m_q[10:1]};
                m_c = res;
            end else if (y <= 6) begin
                m_ca[y-1] = res;
            end
        end
        e.word = model_word();
        e.inv = inv;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, GT, 5'b11111, 3'd0, 1'b1, 1'b1, tag);
    endtask

    // Monitor: compare design outputs after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(status_o, invalid_o, e.word, e.inv, e.tag);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status_o, invalid_o, 32'h0, 1'b0, "R1 reset state");
        rst_n = 1'b1;

        // R2: result selection per relation, queued writes (R3)
        drive(1, GT, 5'b10000, 0, 0, 0, "R2 greater selects mask bit 4");
        drive(1, LT, 5'b10000, 0, 0, 0, "R2 less ignores mask bit 4");
        drive(1, LT, 5'b01000, 0, 0, 0, "R2 less selects mask bit 3");
        drive(1, EQ, 5'b00100, 0, 0, 0, "R2 equal selects mask bit 2");
        drive(1, UN, 5'b00010, 0, 1, 0, "R2 unordered selects mask bit 1");
        drive(1, EQ, 5'b11010, 0, 0, 0, "R2 equal with bit 2 clear");

        // R3: long queued run so old bits fall off the low end
        for (int i = 0; i < 13; i++)
            drive(1, GT, {(i % 3 != 1), 4'b0000}, 0, 0, 0, "R3 queue shift and drop");
        for (int i = 0; i < 12; i++)
            drive(1, GT, 5'b00000, 0, 0, 0, "R3 queue drains zeros");

        // R4: targeted writes to every index
        drive(1, GT, 5'b10000, 0, 0, 0, "R3 set current bit");
        for (int y = 1; y <= 6; y++)
            drive(1, LT, 5'b01000, 3'(y), 0, 0, "R4 targeted write sets bit");
        drive(1, EQ, 5'b00000, 3'd3, 0, 0, "R4 targeted write clears bit");

        // R5: out-of-range index ignored
        drive(1, GT, 5'b10000, 3'd7, 1, 1, "R5 index 7 ignored");
        drive(1, GT, 5'b00000, 3'd7, 0, 0, "R5 index 7 with zero result ignored");

        // R6: idle
        idle("R6 idle hold");
        idle("R6 idle hold again");

        // R7: illegal relation codes
        drive(1, 4'b0000, 5'b11111, 0, 1, 1, "R7 zero relation dropped");
        drive(1, 4'b0011, 5'b00001, 0, 1, 1, "R7 two-hot relation dropped");
        drive(1, 4'b1111, 5'b00000, 3'd2, 1, 1, "R7 all-ones relation dropped on target");

        // R8/R9: invalid semantics and pulse timing
        drive(1, UN, 5'b00011, 0, 1, 0, "R8 signaling compare with qNaN raises invalid");
        drive(1, UN, 5'b00010, 0, 1, 0, "R8 quiet compare with qNaN no invalid");
        drive(1, UN, 5'b00010, 3'd5, 1, 1, "R8 quiet compare with sNaN raises invalid");
        drive(1, GT, 5'b10001, 0, 0, 0, "R8 signaling compare without NaN");
        idle("R9 invalid drops after one cycle");
        drive(1, UN, 5'b00011, 3'd1, 1, 1, "R9 invalid with targeted write");
        idle("R9 pulse ends; R10 unused bits zero");

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(status_o, invalid_o, 32'h0, 1'b0, "R1 reset mid-run");
        m_c = 1'b0; m_q = '0; m_ca = '0;
        rst_n = 1'b1;
        drive(1, GT, 5'b10000, 0, 0, 0, "R1 first compare after reset");
        idle("R6 idle after reset");

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule